// File: doc/BRIEF.md
# Dual-Limit Event Counter with Waveform Output

This block is a 16-bit event counter with a small register interface. Software can reach four registers: the running count, two limit values and a control word. The counter advances by one on each accepted event. It returns to zero in the same cycle that it reaches the limit in force, so the limit value never stays in the count register. Events are taken only on a strobe that comes once every four clocks. They come from one of three places: that internal quarter-rate strobe itself, an external pin passed through a synchroniser, or a chaining input driven by another counter's terminal-count pulse.

The output pin has two forms. In single-limit mode it drops low for one clock at each terminal count and is otherwise high. In dual-limit mode every terminal count hands control from one limit to the other. The pin is high while the first limit governs and low while the second governs, so the two limits together set the period and the duty cycle. The terminal-count pulse is also brought out so that another instance can use it as a prescaler.

Top module: `evt_timer`

## Requirements
- R1: After reset the count reads 0, the control word reads 0 (disabled, single-limit, internal source, first limit in control), `tmr_out` is 1 and `tc_out` is 0.
- R2: Register addresses are 0 = count, 1 = first limit, 2 = second limit, 3 = control. `rdata` shows the addressed register in the same cycle. The count can be written while counting, and a write wins over an event in the same cycle.
- R3: Control bits are: bit 0 enable, bit 1 dual-limit mode, bits 3:2 source (00 internal quarter-rate, 01 external pin, 10 chaining input, 11 none), and bit 4 read-only (1 = second limit in control). Writes to bit 4 are ignored.
- R4: Each event raises the count by one. When the incremented value equals the limit in control, the count becomes 0 in that cycle and `tc_out` is high for that one cycle.
- R5: In single-limit mode the first limit always governs, and `tmr_out` is low for exactly the one clock in which `tc_out` is high.
- R6: Events are accepted only on the strobe that comes once every four clocks. With the internal source and limit M, terminal counts are 4*M clocks apart.
- R7: In dual-limit mode each terminal count swaps the limit in control. `tmr_out` is 1 while the first limit governs and 0 while the second governs. Writing the control word with bit 1 clear returns control to the first limit.
- R8: With the external source, each rising edge of `ext_in` passes a two-flop synchroniser and counts as exactly one event. The count reflects it within 8 clocks.
- R9: With the chaining source, each rising edge of `pre_in` counts as exactly one event.
- R10: While disabled, or with source 11, the count does not change and `tc_out` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select for write and read |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data of the addressed register |
| ext_in | input | 1 | Asynchronous external event pin |
| pre_in | input | 1 | Chaining event input (another counter's `tc_out`) |
| tmr_out | output | 1 | Waveform output |
| tc_out | output | 1 | One-clock terminal-count pulse |

## Verification
The bench builds the block with its default width of 16, a sampling divider of 4 and two synchroniser stages. The default divider makes the 4*M spacing of terminal counts and the 8-clock external latency exact figures that the bench can check. Small limit values (1, 3, 5) bring many terminal counts into a short run, so the bench can measure the period and the output level on both limits of the dual mode several times over. A large limit keeps the count away from wrapping while the external and chaining sources are counted edge by edge.

// File: rtl/evt_timer.sv
module evt_timer #(
  parameter int W    = 16,
  parameter int DIV  = 4,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic         ext_in,
  input  logic         pre_in,
  output logic         tmr_out,
  output logic         tc_out
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [W-1:0]  count, pmax, smax;
  logic          en, dual, sel, tc_q;
  logic [1:0]    src;
  logic [PW-1:0] phase;
  logic [SYNC:0] ext_sh;
  logic          pre_q, pend_e, pend_p;

  wire tick    = (phase == PW'(DIV - 1));
  wire edge_e  = ext_sh[SYNC-1] & ~ext_sh[SYNC];
  wire edge_p  = pre_in & ~pre_q;
  wire have_e  = pend_e | edge_e;
  wire have_p  = pend_p | edge_p;
  wire src_ok  = (src == 2'd0) | ((src == 2'd1) & have_e) | ((src == 2'd2) & have_p);
  wire event_i = tick & en & src_ok;
  wire [W-1:0] act_max = (dual & sel) ? smax : pmax;
  wire [W-1:0] nxt     = count + 1'b1;
  wire hit     = (nxt == act_max);
  wire cnt_wr  = wr_en & (addr == 2'd0);

  assign tc_out  = tc_q;
  assign tmr_out = dual ? ~sel : ~tc_q;

  always_comb begin
    case (addr)
      2'd0:    rdata = count;
      2'd1:    rdata = pmax;
      2'd2:    rdata = smax;
      default: rdata = {{(W-5){1'b0}}, sel, src, dual, en};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= '0;
      ext_sh <= '0;
      pre_q  <= 1'b0;
      pend_e <= 1'b0;
      pend_p <= 1'b0;
    end else begin
      phase  <= tick ? '0 : phase + 1'b1;
      ext_sh <= {ext_sh[SYNC-1:0], ext_in};
      pre_q  <= pre_in;
      pend_e <= tick ? 1'b0 : have_e;
      pend_p <= tick ? 1'b0 : have_p;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      pmax  <= '0;
      smax  <= '0;
      en    <= 1'b0;
      dual  <= 1'b0;
      src   <= 2'd0;
      sel   <= 1'b0;
      tc_q  <= 1'b0;
    end else begin
      tc_q <= 1'b0;
      if (event_i && !cnt_wr) begin
        if (hit) begin
          count <= '0;
          tc_q  <= 1'b1;
          if (dual) sel <= ~sel;
        end else begin
          count <= nxt;
        end
      end
      if (wr_en) begin
        case (addr)
          2'd0: count <= wdata;
          2'd1: pmax  <= wdata;
          2'd2: smax  <= wdata;
          default: begin
            en   <= wdata[0];
            dual <= wdata[1];
            src  <= wdata[3:2];
            if (!wdata[1]) sel <= 1'b0;
          end
        endcase
      end
    end
  end

  p_wrap_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tc_out |-> (count == '0));

  p_quarter_rate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cnt_wr) && (count != $past(count))) |-> ($past(phase) == PW'(DIV - 1)));

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!dual && !tmr_out && !wr_en) |=> tmr_out);

  p_dual_swap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_out && dual && !$past(wr_en)) |-> (sel != $past(sel)));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !wr_en) |=> ($stable(count) && !tc_out));
endmodule

// File: tb/evt_timer_test.sv
module evt_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        ext_in = 1'b0;
  logic        pre_in = 1'b0;
  logic        tmr_out, tc_out;

  int checks = 0, errors = 0;
  int exp_q[$];
  bit restart = 1'b0;
  longint cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  evt_timer uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
                 .rdata(rdata), .ext_in(ext_in), .pre_in(pre_in), .tmr_out(tmr_out), .tc_out(tc_out));

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops expected (interval*2 + level) on each terminal count.
  longint last_t = -1;
  always @(negedge clk) begin
    if (restart) last_t = -1;
    if (tc_out) begin
      if (last_t >= 0 && exp_q.size() > 0) begin
        int item;
        item = exp_q.pop_front();
        chk("R6 period", cyc - last_t, item / 2);
        chk("R5/R7 level at terminal count", tmr_out, item % 2);
      end
      last_t = cyc;
    end
  end

  task automatic run(input int p, input int s, input bit dual_m, input int n);
    wr(2'd3, 16'h0000);
    wr(2'd1, 16'(p));
    wr(2'd2, 16'(s));
    wr(2'd0, 16'h0000);
    @(negedge clk) restart = 1'b1;
    @(negedge clk) restart = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (!dual_m)    exp_q.push_back(8 * p + 0);
      else if (i % 2 == 0) exp_q.push_back(8 * s + 1);
      else            exp_q.push_back(8 * p + 0);
    end
    wr(2'd3, {14'd0, dual_m, 1'b1});
    for (int k = 0; k < 4000 && exp_q.size() > 0; k++) @(negedge clk);
    chk("R6 all terminal counts seen", exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    logic [15:0] v;
    int lowc;
    fork
      begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    join_none

    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    rd(2'd0, v); chk("R1 count", v, 0);
    rd(2'd3, v); chk("R1 control", v, 0);
    chk("R1 tmr_out", tmr_out, 1);
    chk("R1 tc_out", tc_out, 0);

    // R2 register map readback, R3 read-only bit 4 ignored on write
    wr(2'd1, 16'h1234); rd(2'd1, v); chk("R2 first limit", v, 16'h1234);
    wr(2'd2, 16'hBEEF); rd(2'd2, v); chk("R2 second limit", v, 16'hBEEF);
    wr(2'd3, 16'h001A); rd(2'd3, v); chk("R3 control bit4 ignored", v, 16'h000A);

    // R10 disabled: count frozen, tmr_out high
    wr(2'd3, 16'h0000); wr(2'd1, 16'd1000); wr(2'd0, 16'd5);
    idle(40); rd(2'd0, v); chk("R10 disabled count", v, 5);
    chk("R10 disabled tmr_out", tmr_out, 1);
    // R10 source 11 enabled: no events
    wr(2'd3, 16'h000D); idle(40); rd(2'd0, v); chk("R10 no-source count", v, 5);

    // R6 internal quarter rate: 40 clocks -> 10 events
    wr(2'd3, 16'h0000); wr(2'd0, 16'd0); wr(2'd3, 16'h0001);
    idle(40); wr(2'd3, 16'h0000); rd(2'd0, v);
    chk("R6 quarter-rate count", (v >= 10 && v <= 11), 1);

    // R2 write while running is taken as written
    wr(2'd3, 16'h0001);
    @(negedge clk); wr_en = 1'b1; addr = 2'd0; wdata = 16'd300;
    @(negedge clk); wr_en = 1'b0; #1 chk("R2 write while running", rdata, 300);
    wr(2'd3, 16'h0000);

    // R4/R5/R6 single mode
    run(1, 9, 1'b0, 5);
    run(5, 9, 1'b0, 4);
    // R5 low exactly one clock
    wr(2'd3, 16'h0000); wr(2'd1, 16'd3); wr(2'd0, 16'd0); wr(2'd3, 16'h0001);
    lowc = 0;
    for (int k = 0; k < 48; k++) begin @(negedge clk); if (!tmr_out) lowc++; end
    chk("R5 low clocks over 48", lowc, 4);
    // R4 wrap: count never holds the limit
    wr(2'd3, 16'h0000); rd(2'd0, v); chk("R4 count below limit", (v < 3), 1);

    // R7 dual mode alternation
    run(3, 5, 1'b1, 6);
    wr(2'd3, 16'h0002);
    rd(2'd3, v); chk("R7 status matches pin", v[4], !tmr_out);
    wr(2'd3, 16'h0000);
    rd(2'd3, v); chk("R7 clear returns to first", v[4], 0);
    chk("R7 pin high after clear", tmr_out, 1);

    // R8 external source
    wr(2'd1, 16'd1000); wr(2'd0, 16'd0); wr(2'd3, 16'h0005);
    idle(20); rd(2'd0, v); chk("R8 no edge no count", v, 0);
    @(negedge clk) ext_in = 1'b1;
    idle(8); rd(2'd0, v); chk("R8 latency within 8", v, 1);
    @(negedge clk) ext_in = 1'b0; idle(6);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk) ext_in = 1'b1; idle(6);
      @(negedge clk) ext_in = 1'b0; idle(6);
    end
    idle(10); rd(2'd0, v); chk("R8 edge count", v, 6);

    // R9 chaining source
    wr(2'd3, 16'h0000); wr(2'd0, 16'd0); wr(2'd3, 16'h0009);
    for (int i = 0; i < 7; i++) begin
      @(negedge clk) pre_in = 1'b1;
      @(negedge clk) pre_in = 1'b0;
      idle(5);
    end
    idle(10); rd(2'd0, v); chk("R9 chained count", v, 7);
    @(negedge clk) pre_in = 1'b1; idle(20); @(negedge clk) pre_in = 1'b0;
    idle(8); rd(2'd0, v); chk("R9 long high is one event", v, 8);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule